// File: doc/BRIEF.md
# LED Activity Combiner with Pulse Stretcher

This block drives a bank of LED pins from a set of network status event lines. Each LED lane has its own enable mask over the event sources. The enabled events are merged into one activity indication per lane. A lane can hold that indication for a few periods of a slow tick, so that events only microseconds long stay visible to the eye. Each pin can be driven as an active-high push-pull output, or as an active-low open-drain output, which is emulated here with a data level and an output enable.

Event inputs may change at any time. They pass through a synchroniser into the system clock domain. The slow tick comes from a divider counter on the system clock, with a period of about 26 ms in the default setting. The stretcher is a short shift register that advances on the slow tick and shifts in zeros. A lane that sees activity loads it to all ones with priority over the shift. The lane stays lit while any bit of that register is set. The configuration inputs come from a register bank outside this block. That bank is expected to reset every lane to open-drain with stretching on, with lane 0 watching link status and the other lanes watching receive and transmit activity.

Top module: `led_activity_drv`

## Requirements
- R1: While rst_ni is low, every lane is dark. A push-pull lane shows led_o=0 and led_oe_o=1. An open-drain lane shows led_o=0 and led_oe_o=0.
- R2: Lane l is active when any event bit s has evt_i[s]=1 and cfg_en_i[l*8+s]=1. Source bits are: 0 collision, 1 full-duplex link, 2 link up, 3 receive, 4 receive address match, 5 transmit, 6 wake packet seen, 7 100 Mb/s speed.
- R3: An event level present at clock edge n lights the lane from clock edge n+2 onward, so it is visible after the third edge. There are two synchroniser stages and one stretcher register.
- R4: With cfg_stretch_i[l]=1, the slow tick fires at every TICK_DIV-th clock edge after reset release. A lane whose activity ends stays lit until the third slow tick that follows its last load. For a one-cycle activity, the lane is lit for 2*TICK_DIV+1 to 3*TICK_DIV cycles.
- R5: Activity during stretching reloads the full stretch, so the hold time restarts from the newest activity.
- R6: With cfg_stretch_i[l]=0, the lane is lit exactly in the cycles when its activity, delayed as in R3, is present. It goes dark one cycle after the activity ends.
- R7: With cfg_pushpull_i[l]=1 (push-pull, active high), led_o[l] equals the lit state and led_oe_o[l] is 1.
- R8: With cfg_pushpull_i[l]=0 (open drain, active low), led_oe_o[l] equals the lit state and led_o[l] is 0.
- R9: An event whose enable bit is 0 has no effect. With every enable cleared, all lanes stay dark whatever evt_i does.
- R10: The lanes are independent. An event lights only the lanes that enable its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | NUM_SRC | Asynchronous status event lines |
| cfg_en_i | input | NUM_LEDS*NUM_SRC | Per-lane source enables, lane l at bits l*NUM_SRC+s |
| cfg_stretch_i | input | NUM_LEDS | 1 enables stretching for the lane |
| cfg_pushpull_i | input | NUM_LEDS | 1 selects push-pull active high, 0 open-drain active low |
| led_o | output | NUM_LEDS | Pin data level |
| led_oe_o | output | NUM_LEDS | Pin output enable |

## Verification
Every result is due at a fixed edge. An event present at edge n shows on the pins after edge n+2. A stretched lane stays lit until the third slow tick after its last load, and the slow tick lands on every TICK_DIV-th edge counted from reset release. The bench drives inputs on falling edges and samples pins on falling edges. A cycle-level model replays this timing: it delays events by two edges, reloads a three-tick budget on activity, and spends one tick on each divider edge. Directed checks then sample exactly at edges one, two and three after a pulse, and measure stretch lengths against the 2*TICK_DIV+1 to 3*TICK_DIV window.

// File: rtl/led_act_pkg.sv
package led_act_pkg;

  localparam int unsigned SRC_COUNT    = 8;
  localparam int unsigned STRETCH_BITS = 3;

  // event source bit positions
  localparam int unsigned SRC_COLLISION = 0;
  localparam int unsigned SRC_FULL_DPX  = 1;
  localparam int unsigned SRC_LINK_UP   = 2;
  localparam int unsigned SRC_RX        = 3;
  localparam int unsigned SRC_RX_MATCH  = 4;
  localparam int unsigned SRC_TX        = 5;
  localparam int unsigned SRC_WAKE_PKT  = 6;
  localparam int unsigned SRC_FAST_LINK = 7;

  typedef enum logic {
    PIN_OPEN_DRAIN = 1'b0,
    PIN_PUSH_PULL  = 1'b1
  } pin_mode_e;

endpackage

// File: rtl/led_evt_sync.sv
module led_evt_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stg_d[g] = async_i;
    end else begin : g_next
      assign stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[g] <= '0;
      end else begin
        stg_q[g] <= stg_d[g];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/led_slow_tick.sv
module led_slow_tick #(
  parameter int unsigned DIV = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_wrap;

  assign cnt_wrap = (cnt_q == LAST);

  always_comb begin
    if (cnt_wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = cnt_wrap;

endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_act_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned STR_BITS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               stretch_i,
  input  logic               pushpull_i,
  output logic               hit_o,
  output logic               led_o,
  output logic               oe_o
);

  logic [STR_BITS-1:0] hold_q, hold_d;
  logic                hold_en;
  logic                lit;
  pin_mode_e           mode;

  assign hit_o = |(evt_i & en_i);
  assign mode  = pin_mode_e'(pushpull_i);

  // activity load has priority over the slow shift
  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (hit_o) begin
      hold_en = 1'b1;
      hold_d  = '1;
    end else if (!stretch_i) begin
      hold_en = 1'b1;
      hold_d  = '0;
    end else if (tick_i) begin
      hold_en = 1'b1;
      hold_d  = {hold_q[STR_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign lit = |hold_q;

  always_comb begin
    unique case (mode)
      PIN_PUSH_PULL: begin
        led_o = lit;
        oe_o  = 1'b1;
      end
      default: begin
        led_o = 1'b0;
        oe_o  = lit;
      end
    endcase
  end

endmodule

// File: rtl/led_activity_drv.sv
module led_activity_drv
  import led_act_pkg::*;
#(
  parameter int unsigned NUM_LEDS     = 4,
  parameter int unsigned NUM_SRC      = SRC_COUNT,
  parameter int unsigned TICK_DIV     = 5_000_000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STRETCH_LEN  = STRETCH_BITS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SRC-1:0]           evt_i,
  input  logic [NUM_LEDS*NUM_SRC-1:0]  cfg_en_i,
  input  logic [NUM_LEDS-1:0]          cfg_stretch_i,
  input  logic [NUM_LEDS-1:0]          cfg_pushpull_i,
  output logic [NUM_LEDS-1:0]          led_o,
  output logic [NUM_LEDS-1:0]          led_oe_o
);

  logic [NUM_SRC-1:0]  evt_s;
  logic                slow_tick;
  logic [NUM_LEDS-1:0] lane_hit;

  led_evt_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (evt_i),
    .sync_o  (evt_s)
  );

  led_slow_tick #(
    .DIV (TICK_DIV)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (slow_tick)
  );

  for (genvar l = 0; l < NUM_LEDS; l++) begin : g_lane
    led_lane #(
      .NUM_SRC  (NUM_SRC),
      .STR_BITS (STRETCH_LEN)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (slow_tick),
      .evt_i      (evt_s),
      .en_i       (cfg_en_i[l*NUM_SRC +: NUM_SRC]),
      .stretch_i  (cfg_stretch_i[l]),
      .pushpull_i (cfg_pushpull_i[l]),
      .hit_o      (lane_hit[l]),
      .led_o      (led_o[l]),
      .oe_o       (led_oe_o[l])
    );
  end

endmodule

// File: rtl/led_activity_chk.sv
module led_activity_chk #(
  parameter int unsigned NUM_LEDS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_LEDS-1:0] cfg_stretch_i,
  input logic [NUM_LEDS-1:0] cfg_pushpull_i,
  input logic [NUM_LEDS-1:0] led_o,
  input logic [NUM_LEDS-1:0] led_oe_o,
  input logic [NUM_LEDS-1:0] hit_i,
  input logic                tick_i
);

  logic [NUM_LEDS-1:0] lit;

  for (genvar l = 0; l < NUM_LEDS; l++) begin : g_chk
    assign lit[l] = cfg_pushpull_i[l] ? led_o[l] : led_oe_o[l];

    AST_RESET_DARK: assert property (@(posedge clk_i) !rst_ni |-> !lit[l]); // R1

    AST_PUSHPULL_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_pushpull_i[l] |-> led_oe_o[l]); // R7

    AST_OPENDRAIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_pushpull_i[l] |-> !led_o[l]); // R8

    AST_HIT_LIGHTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(hit_i[l]) |-> lit[l]); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cfg_stretch_i[l]) && $past(lit[l]) && !$past(tick_i)) |-> lit[l]); // R4

    AST_DIRECT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(cfg_stretch_i[l]) |-> (lit[l] == $past(hit_i[l]))); // R6
  end

endmodule

bind led_activity_drv led_activity_chk #(
  .NUM_LEDS (NUM_LEDS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_stretch_i  (cfg_stretch_i),
  .cfg_pushpull_i (cfg_pushpull_i),
  .led_o          (led_o),
  .led_oe_o       (led_oe_o),
  .hit_i          (lane_hit),
  .tick_i         (slow_tick)
);

// File: tb/led_activity_drv_test.sv
`timescale 1ns/1ps
module led_activity_drv_test;

  localparam int NL  = 4;
  localparam int NS  = 8;
  localparam int DIV = 8;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic [NS-1:0]    evt;
  logic [NL*NS-1:0] en;
  logic [NL-1:0]    str, pp;
  logic [NL-1:0]    led, oe;

  int checks = 0;
  int fails  = 0;
  bit sb_on  = 1'b0;
  bit done   = 1'b0;

  int            budget [NL];
  logic [NS-1:0] d1, d2;
  int            edge_n;

  always #2.5 clk = ~clk;

  led_activity_drv #(
    .NUM_LEDS (NL),
    .NUM_SRC  (NS),
    .TICK_DIV (DIV)
  ) uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .evt_i          (evt),
    .cfg_en_i       (en),
    .cfg_stretch_i  (str),
    .cfg_pushpull_i (pp),
    .led_o          (led),
    .led_oe_o       (oe)
  );

  function automatic bit pin_lit(int l);
    return pp[l] ? led[l] : oe[l];
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // cycle-level model: events seen two edges late, 3-tick budget per load
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_n = 0;
      d1 = '0;
      d2 = '0;
      for (int l = 0; l < NL; l++) budget[l] = 0;
    end else begin
      edge_n++;
      for (int l = 0; l < NL; l++) begin
        if (|(d2 & en[l*NS +: NS])) budget[l] = 3;
        else if (!str[l]) budget[l] = 0;
        else if ((edge_n % DIV == 0) && budget[l] > 0) budget[l]--;
      end
      d2 = d1;
      d1 = evt;
    end
  end

  always @(negedge clk) begin
    if (sb_on && rst_ni) begin
      for (int l = 0; l < NL; l++) begin
        check(pin_lit(l) == (budget[l] > 0), str[l] ? "R4" : "R6",
              $sformatf("lane %0d lit", l), pin_lit(l), int'(budget[l] > 0));
        if (pp[l]) check(oe[l] == 1'b1, "R7", $sformatf("lane %0d oe", l), oe[l], 1);
        else       check(led[l] == 1'b0, "R8", $sformatf("lane %0d led", l), led[l], 0);
      end
    end
  end

  task automatic pulse(logic [NS-1:0] v);
    @(negedge clk) evt = v;
    @(negedge clk) evt = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    evt    = '0;
    en     = '0;
    str    = 4'b0011;
    pp     = 4'b1010;
    idle(3);
    // R1 reset levels
    for (int l = 0; l < NL; l++) begin
      check(led[l] == 1'b0, "R1", $sformatf("reset led %0d", l), led[l], 0);
      check(oe[l] == pp[l], "R1", $sformatf("reset oe %0d", l), oe[l], pp[l]);
    end
    @(negedge clk) rst_ni = 1'b1;
    sb_on = 1'b1;

    // R3 latency on lane 3 (direct, push-pull), source 3
    en[3*NS+3] = 1'b1;
    @(negedge clk) evt = 8'h08;
    @(negedge clk) evt = '0;
    check(led[3] == 1'b0, "R3", "after 1 edge", led[3], 0);
    @(negedge clk);
    check(led[3] == 1'b0, "R3", "after 2 edges", led[3], 0);
    @(negedge clk);
    check(led[3] == 1'b1, "R3", "after 3 edges", led[3], 1);
    @(negedge clk);
    check(led[3] == 1'b0, "R6", "dark after one cycle", led[3], 0);
    idle(4);

    // R2 OR of enabled sources on lane 2 (direct, open drain)
    en = '0;
    en[2*NS+2] = 1'b1;
    en[2*NS+5] = 1'b1;
    pulse(8'h10);
    for (int i = 0; i < 4; i++) begin
      check(oe[2] == 1'b0, "R2", "disabled source 4", oe[2], 0);
      @(negedge clk);
    end
    @(negedge clk) evt = 8'h20;
    @(negedge clk) evt = '0;
    @(negedge clk);
    @(negedge clk);
    check(oe[2] == 1'b1, "R2", "enabled source 5", oe[2], 1);
    idle(4);

    // R4 stretch length on lane 0 (stretch, open drain)
    en = '0;
    en[0*NS+0] = 1'b1;
    begin
      int cnt = 0;
      pulse(8'h01);
      for (int i = 0; i < 4*DIV+6; i++) begin
        if (oe[0]) cnt++;
        @(negedge clk);
      end
      check(cnt >= 2*DIV+1 && cnt <= 3*DIV, "R4", "stretch length", cnt, 2*DIV+1);
    end

    // R5 reload on lane 1 (stretch, push-pull)
    en = '0;
    en[1*NS+1] = 1'b1;
    pulse(8'h02);
    idle(2*DIV-1);
    pulse(8'h02);
    idle(2*DIV+1);
    check(led[1] == 1'b1, "R5", "reload extends hold", led[1], 1);
    idle(4*DIV);

    // R9 all enables cleared
    en  = '0;
    evt = '1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++)
        check(pin_lit(l) == 1'b0, "R9", $sformatf("lane %0d dark", l), pin_lit(l), 0);
    end
    evt = '0;
    idle(4);

    // R10 sweep: every enable offset against every source, two mode sets
    for (int p = 0; p < 2; p++) begin
      str = p ? 4'b1100 : 4'b0011;
      pp  = p ? 4'b0101 : 4'b1010;
      for (int e = 0; e < NS; e++) begin
        for (int s = 0; s < NS; s++) begin
          en = '0;
          for (int l = 0; l < NL; l++) en[l*NS + ((e+l)%NS)] = 1'b1;
          @(negedge clk) evt = NS'(1) << s;
          @(negedge clk) evt = '0;
          @(negedge clk);
          @(negedge clk);
          for (int l = 0; l < NL; l++)
            check(pin_lit(l) == (((e+l)%NS) == s), "R10",
                  $sformatf("lane %0d e%0d s%0d", l, e, s),
                  pin_lit(l), int'(((e+l)%NS) == s));
          idle(3*DIV+4);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule